// File: doc/BRIEF.md
# SAR ADC Digital Controller

This block is the digital half of an 8-bit successive-approximation converter in a small microcontroller. Software reaches it through a byte-wide register port. The port has a control register at offset 0xD9 and a result register at offset 0xDA. The control register holds the following:

- the channel number;
- a completion flag;
- a plain bit that powers the reference ladder.

The analog parts sit outside the block: the resistor ladder, the channel switch tree and the comparator. The block drives them with a channel select, a ladder enable and an 8-bit trial code. It reads back one comparator bit, which is 1 when the selected input is at or above the trial level.

Software starts a conversion by writing the control register with the completion flag at 0. The sequencer then runs for exactly 50 clock cycles. The first 10 cycles form the input-sampling phase, and the trial code is zero during them. The remaining 40 cycles hold eight 5-cycle trials, from the most significant bit down to the least. At the end of the window the block stores the result, sets the flag and raises a one-cycle interrupt request.

Top module: `sar_adc_ctrl`

## Requirements
- R1: After reset the control register reads 0x08, the result register reads 0x00, and irq, ladder_en, chan_sel and trial_code are all 0. The control register layout is: channel in bits 2..0, flag in bit 3, ladder bit in bit 4, and zeros in bits 7..5.
- R2: A write to offset 0xD9 with bit 3 = 0 starts a conversion. After that write edge the flag reads 0, and chan_sel takes the written bits 2..0, reduced to the channel count.
- R3: A conversion ends exactly 50 clock edges after its start edge. After that edge the flag reads 1 and irq is high for exactly one cycle.
- R4: The search tests bits from the MSB to the LSB and keeps a bit when cmp_in is 1. With an ideal comparator the result therefore equals the largest code that does not exceed the input.
- R5: The result register at offset 0xDA holds the last completed value. It does not change while a conversion is running.
- R6: Bit 4 of the control register can be read and written at any time and drives ladder_en directly.
- R7: A write with bit 3 = 1 neither sets the flag nor starts a conversion. Only a finishing conversion sets the flag, and no irq follows such a write.
- R8: During a conversion, a write may change the channel bits that read back. chan_sel keeps the channel latched at the start until the next start.
- R9: A start write during a conversion restarts the conversion from cycle 0. If that write falls on the final edge, the result is not updated and no irq is raised. The restarted conversion ends 50 edges after the restart.
- R10: trial_code is 0 while idle and during the 10 sampling cycles. The trial sequence is: 0x80 at cycle 10 after the start, then one 5-cycle trial per bit, with the comparator sampled in the last cycle of each trial.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_sel | input | 1 | Register access strobe |
| bus_wr | input | 1 | Write when 1 with bus_sel |
| bus_addr | input | 8 | Register offset |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for bus_addr (combinational) |
| cmp_in | input | 1 | Comparator: input at or above trial level |
| chan_sel | output | 3 | Channel latched at start |
| ladder_en | output | 1 | Reference ladder connect |
| trial_code | output | 8 | Trial level to the DAC |
| irq | output | 1 | Conversion-complete pulse |

## Verification
Two functions can fall in the same cycle: the final comparator decision of a conversion, and a software start write that restarts it. The bench lines these up by issuing the restart write so that its write edge is the 50th edge of a running conversion. It then checks three things:
- the flag reads 0 after that edge;
- no irq appears;
- the result register still shows the previous value.

The restarted conversion must then end 50 edges later, with the value of the input as changed just before the restart.

// File: rtl/sar_adc_pkg.sv
package sar_adc_pkg;
  localparam int ADC_BITS    = 8;
  localparam int CONV_CYCLES = 50;
  localparam int STEP_CYCLES = 5;
  localparam int REG_W       = 8;
  localparam int NUM_CHAN    = 8;
  localparam logic [7:0] CTRL_OFS   = 8'hD9;
  localparam logic [7:0] RESULT_OFS = 8'hDA;
  localparam int FLAG_POS   = 3;
  localparam int LADDER_POS = 4;

  // Trial step that a cycle falls in, or -1 inside the sampling phase.
  function automatic int step_index(int cyc, int sample_len, int step_len);
    if (cyc < sample_len) return -1;
    return (cyc - sample_len) / step_len;
  endfunction

  // True in the cycle whose closing edge captures the comparator.
  function automatic bit is_decision(int cyc, int sample_len, int step_len);
    if (cyc < sample_len) return 1'b0;
    return ((cyc - sample_len) % step_len) == (step_len - 1);
  endfunction
endpackage

// File: rtl/sar_adc_timer.sv
module sar_adc_timer #(
  parameter int BITS = sar_adc_pkg::ADC_BITS,
  parameter int CONV = sar_adc_pkg::CONV_CYCLES,
  parameter int STEP = sar_adc_pkg::STEP_CYCLES
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            start,
  output logic            busy,
  output logic [BITS-1:0] trial_mask,
  output logic            decide,
  output logic            finish
);
  localparam int SAMPLE = CONV - BITS * STEP;
  localparam int LAST   = CONV - 1;
  localparam int CNT_W  = $clog2(CONV);

  logic [CNT_W-1:0] cnt;
  int               idx;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy <= 1'b0;
      cnt  <= '0;
    end else if (start) begin
      busy <= 1'b1;
      cnt  <= '0;
    end else if (busy) begin
      if (cnt == CNT_W'(LAST)) begin
        busy <= 1'b0;
        cnt  <= '0;
      end else begin
        cnt <= cnt + 1'b1;
      end
    end
  end

  always_comb begin
    idx        = sar_adc_pkg::step_index(int'(cnt), SAMPLE, STEP);
    trial_mask = '0;
    for (int b = 0; b < BITS; b++) begin
      if (busy && idx == BITS - 1 - b) trial_mask[b] = 1'b1;
    end
  end

  assign decide = busy && !start && sar_adc_pkg::is_decision(int'(cnt), SAMPLE, STEP);
  assign finish = busy && !start && (cnt == CNT_W'(LAST));

  p_restart_zero_r9: assert property (@(posedge clk) disable iff (!rst_n)
    start |=> (busy && cnt == '0));
  p_cnt_bound_r3: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> (int'(cnt) <= LAST));
  p_finish_idle_r3: assert property (@(posedge clk) disable iff (!rst_n)
    finish |=> !busy);
  p_mask_onehot_r10: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(trial_mask));
endmodule

// File: rtl/sar_adc_search.sv
module sar_adc_search #(
  parameter int BITS = sar_adc_pkg::ADC_BITS
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            start,
  input  logic            busy,
  input  logic [BITS-1:0] trial_mask,
  input  logic            decide,
  input  logic            finish,
  input  logic            cmp_in,
  output logic [BITS-1:0] trial_code,
  output logic [BITS-1:0] result_q
);
  logic [BITS-1:0] work;
  logic [BITS-1:0] kept;

  assign kept       = cmp_in ? (work | trial_mask) : work;
  assign trial_code = busy ? (work | trial_mask) : '0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      work     <= '0;
      result_q <= '0;
    end else begin
      if (start)       work <= '0;
      else if (decide) work <= kept;
      if (finish)      result_q <= kept;
    end
  end

  p_result_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !finish |=> $stable(result_q));
  p_msb_first_r4: assert property (@(posedge clk) disable iff (!rst_n)
    trial_mask[BITS-1] |-> (work == '0));
endmodule

// File: rtl/sar_adc_regs.sv
module sar_adc_regs #(
  parameter int NUM_CH = sar_adc_pkg::NUM_CHAN,
  parameter int REG_W  = sar_adc_pkg::REG_W,
  localparam int CH_W  = $clog2(NUM_CH)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             bus_sel,
  input  logic             bus_wr,
  input  logic [7:0]       bus_addr,
  input  logic [REG_W-1:0] bus_wdata,
  output logic [REG_W-1:0] bus_rdata,
  input  logic             conv_done,
  input  logic [REG_W-1:0] result,
  output logic             start,
  output logic [CH_W-1:0]  chan_q,
  output logic             ladder_q,
  output logic             irq_q
);
  import sar_adc_pkg::*;

  logic       ctrl_wr;
  logic [2:0] ch_q;
  logic       done_q;

  assign ctrl_wr = bus_sel && bus_wr && (bus_addr == CTRL_OFS);
  assign start   = ctrl_wr && !bus_wdata[FLAG_POS];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ch_q     <= '0;
      ladder_q <= 1'b0;
      done_q   <= 1'b1;
      chan_q   <= '0;
      irq_q    <= 1'b0;
    end else begin
      if (ctrl_wr) begin
        ch_q     <= bus_wdata[2:0];
        ladder_q <= bus_wdata[LADDER_POS];
      end
      if (start)          done_q <= 1'b0;
      else if (conv_done) done_q <= 1'b1;
      if (start) chan_q <= bus_wdata[CH_W-1:0];
      irq_q <= conv_done;
    end
  end

  always_comb begin
    bus_rdata = '0;
    if (bus_addr == CTRL_OFS) begin
      bus_rdata[2:0]        = ch_q;
      bus_rdata[FLAG_POS]   = done_q;
      bus_rdata[LADDER_POS] = ladder_q;
    end else if (bus_addr == RESULT_OFS) begin
      bus_rdata = result;
    end
  end

  p_start_clears_r2: assert property (@(posedge clk) disable iff (!rst_n)
    start |=> !done_q);
  p_flag_hw_only_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(done_q) |-> $past(conv_done));
  p_irq_pulse_r3: assert property (@(posedge clk) disable iff (!rst_n)
    irq_q |=> !irq_q);
  p_irq_flag_r3: assert property (@(posedge clk) disable iff (!rst_n)
    irq_q |-> done_q);
  p_chan_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !start |=> $stable(chan_q));
endmodule

// File: rtl/sar_adc_ctrl.sv
module sar_adc_ctrl #(
  parameter int NUM_CH = sar_adc_pkg::NUM_CHAN,
  parameter int BITS   = sar_adc_pkg::ADC_BITS,
  parameter int CONV   = sar_adc_pkg::CONV_CYCLES,
  parameter int STEP   = sar_adc_pkg::STEP_CYCLES,
  localparam int CH_W  = $clog2(NUM_CH)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            bus_sel,
  input  logic            bus_wr,
  input  logic [7:0]      bus_addr,
  input  logic [BITS-1:0] bus_wdata,
  output logic [BITS-1:0] bus_rdata,
  input  logic            cmp_in,
  output logic [CH_W-1:0] chan_sel,
  output logic            ladder_en,
  output logic [BITS-1:0] trial_code,
  output logic            irq
);
  logic            start;
  logic            busy;
  logic [BITS-1:0] trial_mask;
  logic            decide;
  logic            finish;
  logic [BITS-1:0] result_q;

  sar_adc_regs #(.NUM_CH(NUM_CH), .REG_W(BITS)) u_regs (
    .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .conv_done(finish), .result(result_q), .start(start),
    .chan_q(chan_sel), .ladder_q(ladder_en), .irq_q(irq)
  );

  sar_adc_timer #(.BITS(BITS), .CONV(CONV), .STEP(STEP)) u_timer (
    .clk(clk), .rst_n(rst_n), .start(start), .busy(busy),
    .trial_mask(trial_mask), .decide(decide), .finish(finish)
  );

  sar_adc_search #(.BITS(BITS)) u_search (
    .clk(clk), .rst_n(rst_n), .start(start), .busy(busy),
    .trial_mask(trial_mask), .decide(decide), .finish(finish),
    .cmp_in(cmp_in), .trial_code(trial_code), .result_q(result_q)
  );

  p_trial_idle_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> (trial_code == '0));
  p_restart_no_irq_r9: assert property (@(posedge clk) disable iff (!rst_n)
    start |=> !irq);
endmodule

// File: tb/sar_adc_ctrl_bench.sv
`timescale 1ns/1ps
module sar_adc_ctrl_bench;
  localparam logic [7:0] CTRL = 8'hD9;
  localparam logic [7:0] RES  = 8'hDA;
  // {channel[2:0], input level[7:0]}
  localparam logic [10:0] VEC [8] = '{
    {3'd0, 8'h00}, {3'd1, 8'hFF}, {3'd2, 8'h80}, {3'd3, 8'h7F},
    {3'd4, 8'h55}, {3'd5, 8'hAA}, {3'd6, 8'h01}, {3'd7, 8'hFE}
  };

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       bus_sel = 1'b0, bus_wr = 1'b0;
  logic [7:0] bus_addr = 8'h00, bus_wdata = 8'h00, bus_rdata;
  logic       cmp_in, ladder_en, irq;
  logic [2:0] chan_sel;
  logic [7:0] trial_code;
  logic [7:0] vin [8];
  int         checks = 0, errors = 0;

  always #2.5 clk = ~clk;

  assign cmp_in = (vin[chan_sel] >= trial_code);

  sar_adc_ctrl u_sar_adc_ctrl (
    .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .cmp_in(cmp_in), .chan_sel(chan_sel), .ladder_en(ladder_en),
    .trial_code(trial_code), .irq(irq)
  );

  function automatic logic [7:0] ideal(input logic [7:0] v);
    logic [7:0] code = 8'h00;
    for (int b = 7; b >= 0; b--) begin
      if (v >= (code | (8'h01 << b))) code = code | (8'h01 << b);
    end
    return code;
  endfunction

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [7:0] d);
    bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_sel = 1'b0; bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [7:0] d);
    bus_addr = a;
    #0.5;
    d = bus_rdata;
  endtask

  task automatic step(inout int n, input int upto);
    while (n < upto) begin @(negedge clk); n++; end
  endtask

  task automatic run_wait(inout int n);
    while (!irq && n < 300) begin @(negedge clk); n++; end
  endtask

  initial begin
    #(100000 * 5);
    checks++; errors++;
    $display("FAIL watchdog actual=0x0 expected=0x1");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    logic [7:0] d;
    int n;
    foreach (vin[i]) vin[i] = 8'h00;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    rd(CTRL, d); check(d == 8'h08, "R1 ctrl", d, 8'h08);
    rd(RES, d);  check(d == 8'h00, "R1 result", d, 0);
    check(irq == 1'b0 && ladder_en == 1'b0, "R1 irq/ladder", {irq, ladder_en}, 0);
    check(chan_sel == 3'd0 && trial_code == 8'h00, "R1 chan/trial", {chan_sel, trial_code}, 0);

    // Vector table: R2, R3, R4
    for (int i = 0; i < 8; i++) begin
      logic [2:0] ch;
      logic [7:0] v;
      ch = VEC[i][10:8]; v = VEC[i][7:0];
      vin[ch] = v;
      @(negedge clk);
      wr(CTRL, {3'b000, 1'b1, 1'b0, ch});
      n = 0;
      rd(CTRL, d); check(d[3] == 1'b0, "R2 flag cleared", d, {d[7:4], 1'b0, d[2:0]});
      check(chan_sel == ch, "R2 channel", chan_sel, ch);
      run_wait(n);
      check(n == 50, "R3 latency", n, 50);
      rd(CTRL, d); check(d[3] == 1'b1, "R3 flag set", d[3], 1);
      rd(RES, d);  check(d == ideal(v), "R4 result", d, ideal(v));
      @(negedge clk);
      check(irq == 1'b0, "R3 irq one cycle", irq, 0);
    end

    // R10 / R5: trial timing and held result during a conversion
    vin[1] = 8'h3C;
    wr(CTRL, 8'h11); n = 0;
    check(trial_code == 8'h00, "R10 trial in sampling c0", trial_code, 0);
    step(n, 9);  check(trial_code == 8'h00, "R10 trial in sampling c9", trial_code, 0);
    step(n, 10); check(trial_code == 8'h80, "R10 first trial", trial_code, 8'h80);
    step(n, 15); check(trial_code == 8'h40, "R10 second trial", trial_code, 8'h40);
    rd(RES, d);  check(d == 8'hFE, "R5 result held", d, 8'hFE);
    run_wait(n);
    check(n == 50, "R3 latency ch1", n, 50);
    rd(RES, d);  check(d == 8'h3C, "R4 result ch1", d, 8'h3C);
    @(negedge clk);
    check(trial_code == 8'h00, "R10 trial idle", trial_code, 0);

    // R7: writing flag=1 does nothing
    wr(CTRL, 8'h0D); n = 0;
    for (int k = 0; k < 60; k++) begin
      @(negedge clk);
      if (irq) n++;
    end
    check(n == 0, "R7 no irq", n, 0);
    rd(CTRL, d); check(d == 8'h0D, "R7 ctrl readback", d, 8'h0D);
    check(chan_sel == 3'd1, "R7 no start channel", chan_sel, 1);

    // R6: ladder bit
    wr(CTRL, 8'h18);
    check(ladder_en == 1'b1, "R6 ladder on", ladder_en, 1);
    rd(CTRL, d); check(d == 8'h18, "R6 readback", d, 8'h18);
    wr(CTRL, 8'h08);
    check(ladder_en == 1'b0, "R6 ladder off", ladder_en, 0);

    // R8: channel change mid-conversion
    vin[2] = 8'h91; vin[6] = 8'h22;
    wr(CTRL, 8'h12); n = 0;
    step(n, 20);
    wr(CTRL, 8'h1E); n++;
    check(chan_sel == 3'd2, "R8 channel held", chan_sel, 2);
    rd(CTRL, d); check(d == 8'h16, "R8 readback", d, 8'h16);
    run_wait(n);
    check(n == 50, "R8 latency", n, 50);
    rd(RES, d); check(d == 8'h91, "R8 result from latched channel", d, 8'h91);
    @(negedge clk);

    // R9: restart mid-conversion
    vin[3] = 8'h47;
    wr(CTRL, 8'h13); n = 0;
    step(n, 30);
    vin[3] = 8'hB4;
    wr(CTRL, 8'h13); n = 0;
    run_wait(n);
    check(n == 50, "R9 restart latency", n, 50);
    rd(RES, d); check(d == 8'hB4, "R9 restart result", d, 8'hB4);
    @(negedge clk);

    // R9: restart on the final edge
    vin[4] = 8'h11;
    wr(CTRL, 8'h14); n = 0;
    step(n, 49);
    vin[4] = 8'h66;
    wr(CTRL, 8'h14); n = 0;
    check(irq == 1'b0, "R9 no irq on collision", irq, 0);
    rd(CTRL, d); check(d[3] == 1'b0, "R9 flag stays low", d[3], 0);
    rd(RES, d);  check(d == 8'hB4, "R9 result not updated", d, 8'hB4);
    run_wait(n);
    check(n == 50, "R9 collision latency", n, 50);
    rd(RES, d);  check(d == 8'h66, "R9 collision result", d, 8'h66);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule